// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one programmable logic cell whose behaviour is fixed by a static configuration word. Five AND terms are formed over a shared input bus, each term choosing its inputs through its own mask. The terms feed a sum with an optional cascade input and a selectable XOR polarity stage. They also serve as sources for the cell's own clock, clock enable, reset, preset and storage-element data.

The storage element can act as a D, T, JK or SR flip-flop, or as a level-sensitive latch. Its clocking is sampled: the whole cell runs on a system clock `clk`. The selected cell clock (one of three global clock lines or a product term) is sampled once per `clk` cycle. A rising edge means the cell clock was sampled high in this cycle and low in the previous one. Reset and preset act within the same cycle, before any clock edge, and the state they force is captured at the next `clk` edge.

The pin output can be registered or combinational, with an output enable from one of several sources. A buried feedback, chosen on its own between registered and combinational, and an inverted foldback term are also produced for use by neighbouring logic.

Top module: `sop_cell`

## Requirements
- R1: Product term k is the AND of the bus bits whose bit in mask slice k (`pt_mask[k*NIN +: NIN]`) is set; an empty mask gives 1. `fold_out` is the inverse of the term indexed by `fold_pt`.
- R2: The sum is the OR of the terms enabled in `or_en`, plus `cas_in` when `cas_in_en` is 1. `cas_out` equals the sum when `cas_out_en` is 1 and is 0 otherwise.
- R3: The combinational result is the sum XOR a second input selected by `xor_sel`: 0 gives constant 0, 1 gives constant 1, 2 gives the term indexed by `xor_pt`, 3 gives constant 0.
- R4: The storage data input is selected by `d_sel`: 0 gives the XOR result, 1 gives the term indexed by `d_pt`, 2 or 3 gives `io_in`.
- R5: The cell clock is selected by `clk_sel`: 0..2 pick `gclk[0..2]`, 3 picks the term indexed by `clk_pt`. The state updates on a sampled rising edge. The cell-clock history reads as low after system reset.
- R6: When `ce_en` is 1 and a global clock is selected, the term indexed by `ce_pt` is a clock enable. While it is 0, edges are ignored and the latch stays closed. With a product-term clock, the enable is inactive.
- R7: With `mode` 0 (D) the edge loads the data. With 1 (T) the state toggles when the data is 1. With 2 (JK), J is the data and K is the term indexed by `k_pt`, and J=K=1 toggles. With 3 (SR), S is the data and R is that same K term, and S=R=1 holds.
- R8: With `mode` 4 the element is a latch. It is transparent while the cell clock is high (and enabled) and holds while it is low.
- R9: `ar_sel` picks the reset: 0 off, 1 `gclr`, 2 the term indexed by `ar_pt`, 3 the OR of both. When `ap_en` is 1, the term indexed by `ap_pt` presets. Reset beats preset. Both take effect in the same cycle.
- R10: `out_reg` = 1 drives `pin_out` from the storage element and 0 from the XOR result. `fb_reg` chooses the same way for `fb_out`, independently.
- R11: `pin_oe` is chosen by `oe_sel`: 0 `oe_pin[0]`, 1 its inverse, 2 `oe_pin[1]`, 3 its inverse, 4 `oe_src[oe_idx]`, 5 constant 1, 6 and 7 constant 0.
- R12: System reset (`rst_n` low) clears the stored state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the whole cell |
| rst_n | input | 1 | Active-low system reset |
| pt_bus | input | NIN | Shared input bus for the product terms |
| pt_mask | input | 5*NIN | AND masks, one NIN-bit slice per term |
| cas_in | input | 1 | Cascade sum from the neighbouring cell |
| cas_out | output | 1 | Cascade sum to the next cell |
| gclk | input | 3 | Global clock lines |
| gclr | input | 1 | Global clear |
| oe_pin | input | 2 | Two output-enable pins |
| io_in | input | 1 | Value read from the cell's pin |
| oe_src | input | NOE | Other pins or cells usable as output enable |
| cfg_word | input | CFG_W | Static configuration word (packed `cell_cfg_t`) |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Buried feedback |
| fold_out | output | 1 | Inverted foldback term |

## Verification
The bench goes after the JK and SR corner where both inputs are 1. A design that swapped the toggle and hold rules would end up with the wrong state after such an edge. It also covers reset and preset asserted together; a design with the priority inverted would show 1 where 0 is due. A clock enable that is ignored, or one applied to a product-term clock, shows up as extra or missing state changes. A latch that is edge-triggered instead of transparent lags the data by a cycle. The first cell-clock sample after system reset must count as an edge when it is high, and a design that kept the old history would miss that load.

// File: rtl/sop_cell_pkg.sv
`timescale 1ns/1ps
package sop_cell_pkg;
    localparam int PT_N   = 5;
    localparam int PTI_W  = 3;
    localparam int OEI_W  = 4;
    localparam int GCLK_N = 3;

    typedef enum logic [2:0] {
        FF_D   = 3'd0,
        FF_T   = 3'd1,
        FF_JK  = 3'd2,
        FF_SR  = 3'd3,
        FF_LAT = 3'd4
    } ff_mode_e;

    typedef struct packed {
        logic [PT_N-1:0]  or_en;
        logic             cas_in_en;
        logic             cas_out_en;
        logic [1:0]       xor_sel;
        logic [PTI_W-1:0] xor_pt;
        logic [1:0]       d_sel;
        logic [PTI_W-1:0] d_pt;
        ff_mode_e         mode;
        logic [PTI_W-1:0] k_pt;
        logic [1:0]       clk_sel;
        logic [PTI_W-1:0] clk_pt;
        logic             ce_en;
        logic [PTI_W-1:0] ce_pt;
        logic [1:0]       ar_sel;
        logic [PTI_W-1:0] ar_pt;
        logic             ap_en;
        logic [PTI_W-1:0] ap_pt;
        logic             out_reg;
        logic             fb_reg;
        logic [PTI_W-1:0] fold_pt;
        logic [2:0]       oe_sel;
        logic [OEI_W-1:0] oe_idx;
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    // Selects one product term; an index past the last term yields 0.
    function automatic logic pick_term(input logic [PT_N-1:0] terms,
                                       input logic [PTI_W-1:0] idx);
        logic r;
        r = 1'b0;
        for (int i = 0; i < PT_N; i++) begin
            if (32'(idx) == i) r = terms[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/sop_pt_array.sv
`timescale 1ns/1ps
module sop_pt_array
    import sop_cell_pkg::*;
#(
    parameter int NIN = 40
) (
    input  logic [NIN-1:0]      bus_i,
    input  logic [PT_N*NIN-1:0] mask_i,
    output logic [PT_N-1:0]     term_o
);
    for (genvar k = 0; k < PT_N; k++) begin : g_term
        logic [NIN-1:0] sel_slice;
        assign sel_slice = mask_i[k*NIN +: NIN];
        // Bits outside the mask are forced high so they do not affect the AND.
        assign term_o[k] = &(bus_i | ~sel_slice);
    end
endmodule

// File: rtl/sop_sum_xor.sv
`timescale 1ns/1ps
module sop_sum_xor
    import sop_cell_pkg::*;
(
    input  logic [PT_N-1:0]  term_i,
    input  logic [PT_N-1:0]  or_en_i,
    input  logic             cas_in_i,
    input  logic             cas_in_en_i,
    input  logic             cas_out_en_i,
    input  logic [1:0]       xor_sel_i,
    input  logic [PTI_W-1:0] xor_pt_i,
    output logic             cas_out_o,
    output logic             xor_o
);
    logic sum;
    logic pol;

    always_comb begin
        sum = |(term_i & or_en_i) | (cas_in_i & cas_in_en_i);
        unique case (xor_sel_i)
            2'd1:    pol = 1'b1;
            2'd2:    pol = pick_term(term_i, xor_pt_i);
            default: pol = 1'b0;
        endcase
        cas_out_o = cas_out_en_i & sum;
        xor_o     = sum ^ pol;
    end
endmodule

// File: rtl/sop_ff_core.sv
`timescale 1ns/1ps
module sop_ff_core
    import sop_cell_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ff_mode_e mode_i,
    input  logic     cclk_i,
    input  logic     ce_i,
    input  logic     d_i,
    input  logic     k_i,
    input  logic     ar_i,
    input  logic     ap_i,
    output logic     view_o,
    output logic     state_o
);
    typedef struct packed {
        logic st;
        logic cprev;
    } ff_st_t;

    ff_st_t cur_d, cur_q;
    logic   fire;
    logic   open_lat;

    always_comb begin
        cur_d       = cur_q;
        cur_d.cprev = cclk_i;
        fire        = cclk_i & ~cur_q.cprev & ce_i;
        open_lat    = cclk_i & ce_i;

        unique case (mode_i)
            FF_T: begin
                if (fire && d_i) cur_d.st = ~cur_q.st;
            end
            FF_JK: begin
                if (fire) begin
                    unique case ({d_i, k_i})
                        2'b11:   cur_d.st = ~cur_q.st;
                        2'b10:   cur_d.st = 1'b1;
                        2'b01:   cur_d.st = 1'b0;
                        default: cur_d.st = cur_q.st;
                    endcase
                end
            end
            FF_SR: begin
                if (fire) begin
                    unique case ({d_i, k_i})
                        2'b10:   cur_d.st = 1'b1;
                        2'b01:   cur_d.st = 1'b0;
                        default: cur_d.st = cur_q.st;
                    endcase
                end
            end
            FF_LAT: begin
                if (open_lat) cur_d.st = d_i;
            end
            default: begin
                if (fire) cur_d.st = d_i;
            end
        endcase

        if (ar_i)      cur_d.st = 1'b0;
        else if (ap_i) cur_d.st = 1'b1;

        if (ar_i)                             view_o = 1'b0;
        else if (ap_i)                        view_o = 1'b1;
        else if (mode_i == FF_LAT && open_lat) view_o = d_i;
        else                                  view_o = cur_q.st;

        state_o = cur_q.st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end
endmodule

// File: rtl/sop_out_ctl.sv
`timescale 1ns/1ps
module sop_out_ctl
    import sop_cell_pkg::*;
#(
    parameter int NOE = 8
) (
    input  logic [PT_N-1:0]  term_i,
    input  logic             view_i,
    input  logic             xor_i,
    input  logic             out_reg_i,
    input  logic             fb_reg_i,
    input  logic [PTI_W-1:0] fold_pt_i,
    input  logic [2:0]       oe_sel_i,
    input  logic [OEI_W-1:0] oe_idx_i,
    input  logic [1:0]       oe_pin_i,
    input  logic [NOE-1:0]   oe_src_i,
    output logic             pin_o,
    output logic             oe_o,
    output logic             fb_o,
    output logic             fold_o
);
    logic src_bit;

    always_comb begin
        src_bit = 1'b0;
        for (int i = 0; i < NOE; i++) begin
            if (32'(oe_idx_i) == i) src_bit = oe_src_i[i];
        end
        unique case (oe_sel_i)
            3'd0:    oe_o = oe_pin_i[0];
            3'd1:    oe_o = ~oe_pin_i[0];
            3'd2:    oe_o = oe_pin_i[1];
            3'd3:    oe_o = ~oe_pin_i[1];
            3'd4:    oe_o = src_bit;
            3'd5:    oe_o = 1'b1;
            default: oe_o = 1'b0;
        endcase
        pin_o  = out_reg_i ? view_i : xor_i;
        fb_o   = fb_reg_i  ? view_i : xor_i;
        fold_o = ~pick_term(term_i, fold_pt_i);
    end
endmodule

// File: rtl/sop_cell.sv
`timescale 1ns/1ps
module sop_cell
    import sop_cell_pkg::*;
#(
    parameter int NIN = 40,
    parameter int NOE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NIN-1:0]      pt_bus,
    input  logic [PT_N*NIN-1:0] pt_mask,
    input  logic                cas_in,
    output logic                cas_out,
    input  logic [GCLK_N-1:0]   gclk,
    input  logic                gclr,
    input  logic [1:0]          oe_pin,
    input  logic                io_in,
    input  logic [NOE-1:0]      oe_src,
    input  logic [CFG_W-1:0]    cfg_word,
    output logic                pin_out,
    output logic                pin_oe,
    output logic                fb_out,
    output logic                fold_out
);
    cell_cfg_t       cfg;
    logic [PT_N-1:0] pt;
    logic            xor_out;
    logic            d_in;
    logic            k_in;
    logic            cell_clk;
    logic            ce_act;
    logic            ar_act;
    logic            ap_act;
    logic            q_view;
    logic            ff_state;
    logic            ar_term;

    assign cfg = cell_cfg_t'(cfg_word);

    sop_pt_array #(.NIN(NIN)) u_terms (
        .bus_i  (pt_bus),
        .mask_i (pt_mask),
        .term_o (pt)
    );

    sop_sum_xor u_sum (
        .term_i       (pt),
        .or_en_i      (cfg.or_en),
        .cas_in_i     (cas_in),
        .cas_in_en_i  (cfg.cas_in_en),
        .cas_out_en_i (cfg.cas_out_en),
        .xor_sel_i    (cfg.xor_sel),
        .xor_pt_i     (cfg.xor_pt),
        .cas_out_o    (cas_out),
        .xor_o        (xor_out)
    );

    // Control decode: clock, enable, data and asynchronous sources.
    always_comb begin
        unique case (cfg.d_sel)
            2'd0:    d_in = xor_out;
            2'd1:    d_in = pick_term(pt, cfg.d_pt);
            default: d_in = io_in;
        endcase
        k_in = pick_term(pt, cfg.k_pt);

        unique case (cfg.clk_sel)
            2'd0:    cell_clk = gclk[0];
            2'd1:    cell_clk = gclk[1];
            2'd2:    cell_clk = gclk[2];
            default: cell_clk = pick_term(pt, cfg.clk_pt);
        endcase
        ce_act = (cfg.ce_en && cfg.clk_sel != 2'd3) ? pick_term(pt, cfg.ce_pt) : 1'b1;

        ar_term = pick_term(pt, cfg.ar_pt);
        unique case (cfg.ar_sel)
            2'd1:    ar_act = gclr;
            2'd2:    ar_act = ar_term;
            2'd3:    ar_act = gclr | ar_term;
            default: ar_act = 1'b0;
        endcase
        ap_act = cfg.ap_en & pick_term(pt, cfg.ap_pt);
    end

    sop_ff_core u_ff (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (cfg.mode),
        .cclk_i  (cell_clk),
        .ce_i    (ce_act),
        .d_i     (d_in),
        .k_i     (k_in),
        .ar_i    (ar_act),
        .ap_i    (ap_act),
        .view_o  (q_view),
        .state_o (ff_state)
    );

    sop_out_ctl #(.NOE(NOE)) u_out (
        .term_i    (pt),
        .view_i    (q_view),
        .xor_i     (xor_out),
        .out_reg_i (cfg.out_reg),
        .fb_reg_i  (cfg.fb_reg),
        .fold_pt_i (cfg.fold_pt),
        .oe_sel_i  (cfg.oe_sel),
        .oe_idx_i  (cfg.oe_idx),
        .oe_pin_i  (oe_pin),
        .oe_src_i  (oe_src),
        .pin_o     (pin_out),
        .oe_o      (pin_oe),
        .fb_o      (fb_out),
        .fold_o    (fold_out)
    );
endmodule

// File: rtl/sop_cell_chk.sv
`timescale 1ns/1ps
module sop_cell_chk
    import sop_cell_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input cell_cfg_t cfg,
    input logic      cell_clk,
    input logic      ce_act,
    input logic      ar_act,
    input logic      ap_act,
    input logic      q_view,
    input logic      ff_state,
    input logic      xor_out,
    input logic      pin_out,
    input logic      fb_out,
    input logic      pin_oe
);
    // R9
    ar_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_act |-> (q_view == 1'b0));

    // R9
    ap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_act && !ar_act) |-> (q_view == 1'b1));

    // R5
    clk_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cell_clk && !ar_act && !ap_act) |=> $stable(ff_state));

    // R6
    ce_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_act && !ar_act && !ap_act) |=> $stable(ff_state));

    // R10
    out_reg_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.out_reg |-> (pin_out == q_view));

    // R10
    fb_comb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.fb_reg |-> (fb_out == xor_out));

    // R11
    oe_force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.oe_sel == 3'd5) |-> pin_oe);
endmodule

bind sop_cell sop_cell_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .cell_clk (cell_clk),
    .ce_act   (ce_act),
    .ar_act   (ar_act),
    .ap_act   (ap_act),
    .q_view   (q_view),
    .ff_state (ff_state),
    .xor_out  (xor_out),
    .pin_out  (pin_out),
    .fb_out   (fb_out),
    .pin_oe   (pin_oe)
);

// File: tb/tb_sop_cell.sv
`timescale 1ns/1ps
module tb_sop_cell;
    import sop_cell_pkg::*;

    localparam int NIN = 8;
    localparam int NOE = 4;
    localparam int RUN = 150;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NIN-1:0]      pt_bus = '0;
    logic [PT_N*NIN-1:0] pt_mask = '0;
    logic                cas_in = 1'b0;
    logic                cas_out;
    logic [GCLK_N-1:0]   gclk = '0;
    logic                gclr = 1'b0;
    logic [1:0]          oe_pin = '0;
    logic                io_in = 1'b0;
    logic [NOE-1:0]      oe_src = '0;
    cell_cfg_t           c;
    logic                pin_out, pin_oe, fb_out, fold_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit mq = 0;
    bit mprev = 0;

    always #4 clk = ~clk;

    sop_cell #(.NIN(NIN), .NOE(NOE)) dut (
        .clk(clk), .rst_n(rst_n), .pt_bus(pt_bus), .pt_mask(pt_mask),
        .cas_in(cas_in), .cas_out(cas_out), .gclk(gclk), .gclr(gclr),
        .oe_pin(oe_pin), .io_in(io_in), .oe_src(oe_src), .cfg_word(c),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .fold_out(fold_out)
    );

    task automatic check(string tag, string what, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    task automatic rand_cfg();
        c = '0;
        c.or_en      = 5'($urandom);
        c.cas_in_en  = 1'($urandom);
        c.cas_out_en = 1'($urandom);
        c.xor_sel    = 2'($urandom);
        c.xor_pt     = 3'($urandom % 5);
        c.d_sel      = 2'($urandom % 3);
        c.d_pt       = 3'($urandom % 5);
        c.mode       = ff_mode_e'(3'($urandom % 5));
        c.k_pt       = 3'($urandom % 5);
        c.clk_sel    = 2'($urandom);
        c.clk_pt     = 3'($urandom % 5);
        c.ce_en      = 1'($urandom);
        c.ce_pt      = 3'($urandom % 5);
        c.ar_sel     = 2'($urandom);
        c.ar_pt      = 3'($urandom % 5);
        c.ap_en      = 1'($urandom);
        c.ap_pt      = 3'($urandom % 5);
        c.out_reg    = 1'($urandom);
        c.fb_reg     = 1'($urandom);
        c.fold_pt    = 3'($urandom % 5);
        c.oe_sel     = 3'($urandom);
        c.oe_idx     = 4'($urandom % NOE);
        pt_mask = '0;
        for (int k = 0; k < PT_N; k++) begin
            int nb;
            nb = $urandom % 3;
            for (int b = 0; b < nb; b++) pt_mask[k*NIN + ($urandom % NIN)] = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        mq = 0;
        mprev = 0;
    endtask

    task automatic step(string tag);
        bit [PT_N-1:0] t;
        bit sum, pol, xo, dd, kk, cc, ce, ar, ap, fire, opn, view, nq;
        @(negedge clk);
        rst_n  = 1'b1;
        pt_bus = NIN'($urandom);
        gclk   = GCLK_N'($urandom);
        gclr   = (($urandom % 4) == 0);
        cas_in = 1'($urandom);
        oe_pin = 2'($urandom);
        io_in  = 1'($urandom);
        oe_src = NOE'($urandom);
        #1;
        for (int k = 0; k < PT_N; k++) begin
            t[k] = 1'b1;
            for (int i = 0; i < NIN; i++)
                if (pt_mask[k*NIN+i] && !pt_bus[i]) t[k] = 1'b0;
        end
        sum = 0;
        for (int k = 0; k < PT_N; k++) if (c.or_en[k] && t[k]) sum = 1;
        if (c.cas_in_en && cas_in) sum = 1;
        case (c.xor_sel)
            2'd1: pol = 1;
            2'd2: pol = t[c.xor_pt];
            default: pol = 0;
        endcase
        xo = sum ^ pol;
        dd = (c.d_sel == 0) ? xo : (c.d_sel == 1) ? t[c.d_pt] : io_in;
        kk = t[c.k_pt];
        cc = (c.clk_sel == 3) ? t[c.clk_pt] : gclk[c.clk_sel];
        ce = (c.clk_sel != 3 && c.ce_en) ? t[c.ce_pt] : 1'b1;
        ar = (c.ar_sel == 1 && gclr) || (c.ar_sel == 2 && t[c.ar_pt]) ||
             (c.ar_sel == 3 && (gclr || t[c.ar_pt]));
        ap = c.ap_en && t[c.ap_pt];
        fire = cc && !mprev && ce;
        opn  = cc && ce;
        nq = mq;
        case (int'(c.mode))
            0: if (fire) nq = dd;
            1: if (fire && dd) nq = !mq;
            2: if (fire) nq = (dd && kk) ? !mq : dd ? 1'b1 : kk ? 1'b0 : mq;
            3: if (fire) nq = (dd && !kk) ? 1'b1 : (!dd && kk) ? 1'b0 : mq;
            default: if (opn) nq = dd;
        endcase
        if (ar) begin
            nq = 0; view = 0;
        end else if (ap) begin
            nq = 1; view = 1;
        end else if (int'(c.mode) == 4 && opn) begin
            view = dd;
        end else begin
            view = mq;
        end
        check(tag, "pin_out", pin_out, c.out_reg ? view : xo);
        check(tag, "fb_out", fb_out, c.fb_reg ? view : xo);
        check(tag, "cas_out", cas_out, c.cas_out_en ? sum : 1'b0);
        check(tag, "fold_out", fold_out, !t[c.fold_pt]);
        case (c.oe_sel)
            3'd0: check(tag, "pin_oe", pin_oe, oe_pin[0]);
            3'd1: check(tag, "pin_oe", pin_oe, !oe_pin[0]);
            3'd2: check(tag, "pin_oe", pin_oe, oe_pin[1]);
            3'd3: check(tag, "pin_oe", pin_oe, !oe_pin[1]);
            3'd4: check(tag, "pin_oe", pin_oe, oe_src[c.oe_idx]);
            3'd5: check(tag, "pin_oe", pin_oe, 1'b1);
            default: check(tag, "pin_oe", pin_oe, 1'b0);
        endcase
        mq = nq;
        mprev = cc;
    endtask

    task automatic run(string tag);
        do_reset();
        for (int n = 0; n < RUN; n++) step(tag);
    endtask

    task automatic quiet_ctl();
        c.ar_sel = 2'd0;
        c.ap_en  = 1'b0;
        c.out_reg = 1'b1;
    endtask

    initial begin
        // R12: state cleared by reset; first high clock sample after reset is an edge
        rand_cfg(); quiet_ctl();
        c.mode = FF_D; c.clk_sel = 2'd0; c.ce_en = 1'b0; c.d_sel = 2'd2;
        do_reset();
        @(negedge clk);
        #1;
        check("R12", "pin_out after reset", pin_out, 1'b0);
        run("R12");

        // R1: product terms and foldback, including empty masks
        for (int f = 0; f < PT_N; f++) begin
            rand_cfg(); c.fold_pt = 3'(f);
            if (f == 0) pt_mask = '0;
            run("R1");
        end
        // R2: cascade in/out combinations
        for (int m = 0; m < 4; m++) begin
            rand_cfg(); c.cas_in_en = m[0]; c.cas_out_en = m[1];
            run("R2");
        end
        // R3: XOR polarity source
        for (int x = 0; x < 4; x++) begin
            rand_cfg(); c.xor_sel = 2'(x); c.out_reg = 1'b0;
            run("R3");
        end
        // R4: data source
        for (int s = 0; s < 3; s++) begin
            rand_cfg(); quiet_ctl(); c.mode = FF_D; c.d_sel = 2'(s);
            run("R4");
        end
        // R5: clock source, no enable
        for (int s = 0; s < 4; s++) begin
            rand_cfg(); quiet_ctl(); c.clk_sel = 2'(s); c.ce_en = 1'b0;
            run("R5");
        end
        // R6: clock enable with each clock source
        for (int s = 0; s < 4; s++) begin
            rand_cfg(); quiet_ctl(); c.clk_sel = 2'(s); c.ce_en = 1'b1;
            run("R6");
        end
        // R7: edge-triggered modes
        for (int m = 0; m < 4; m++) begin
            rand_cfg(); quiet_ctl(); c.mode = ff_mode_e'(3'(m));
            run("R7");
        end
        // R8: latch mode
        for (int r = 0; r < 3; r++) begin
            rand_cfg(); quiet_ctl(); c.mode = FF_LAT;
            run("R8");
        end
        // R9: reset/preset selection and priority
        for (int a = 0; a < 8; a++) begin
            rand_cfg(); c.ar_sel = 2'(a % 4); c.ap_en = a[2]; c.out_reg = 1'b1;
            run("R9");
        end
        // R10: output and feedback path choices
        for (int o = 0; o < 4; o++) begin
            rand_cfg(); c.out_reg = o[0]; c.fb_reg = o[1];
            run("R10");
        end
        // R11: output enable selection
        for (int e = 0; e < 8; e++) begin
            rand_cfg(); c.oe_sel = 3'(e);
            run("R11");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule